// File: doc/BRIEF.md
# Programmable Status Indicator Driver

This block drives a bank of lamp outputs, one per port channel. Each output is a pull-low enable: a 1 turns the pad transistor on and lights a lamp tied to the supply, and a 0 lets the pad float. Each channel follows one of five behaviours. It can mirror that channel's link status or its full-duplex status. It can stay on, stay off, or flash at a fixed slow rate taken from the reference clock. A global selector can replace the per-channel choice for every channel at once.

The same pads carry address straps at power-up. After reset is removed, the block keeps every output released for a fixed number of reference-clock cycles, so the board-level levels can be captured. A power-down input also releases every output. The flash timing comes from one counter shared by all channels, so flashing lamps always turn on and off together.

Top module: `led_ind_top`

## Requirements
- R1: While `rst_n_i` is low, every bit of `led_drive_o` is 0, whatever the mode inputs are.
- R2: After `rst_n_i` rises, `led_drive_o` stays all-zero for the first STRAP_CYCLES rising clock edges. From the next edge on it follows the selected modes.
- R3: Selector code 3'd0 (link) makes a channel's output equal to that channel's `link_up_i` bit, one clock edge later.
- R4: Selector code 3'd1 (duplex) makes a channel's output equal to that channel's `full_dup_i` bit, one clock edge later.
- R5: Selector code 3'd2 drives the output to 1 (lamp lit). Code 3'd3 drives it to 0 (released).
- R6: Selector codes 3'd5, 3'd6 and 3'd7 behave exactly like code 3'd3 (released).
- R7: Selector code 3'd4 (flash) makes the output alternate forever between BLINK_HALF_CYCLES clock cycles at 1 and BLINK_HALF_CYCLES clock cycles at 0.
- R8: All channels in flash mode show the same value on every cycle.
- R9: The flash sequence starts in its lit half at reset. A channel in flash mode therefore reads 1 on the first cycle after the strap window, provided STRAP_CYCLES + 1 < BLINK_HALF_CYCLES.
- R10: When `glb_sel_en_i` is 1, every channel uses `glb_sel_i` and ignores its own field in `ch_sel_i`.
- R11: When `pwrdn_i` is 1, every output is 0 one clock edge later, in any mode. Outputs resume their modes one edge after `pwrdn_i` returns to 0.
- R12: Each channel's mode comes from its own 3-bit field of `ch_sel_i`: channel n uses bits [3n+2:3n]. Channels with different modes do not affect each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 10 MHz reference clock |
| rst_n_i | input | 1 | Active-low reset, asynchronous assertion |
| pwrdn_i | input | 1 | Power-down: release all outputs |
| glb_sel_en_i | input | 1 | Use the global selector for all channels |
| glb_sel_i | input | 3 | Global mode selector code |
| ch_sel_i | input | 3*NUM_CH | Per-channel mode selector codes, channel n at [3n+2:3n] |
| link_up_i | input | NUM_CH | Per-channel link status |
| full_dup_i | input | NUM_CH | Per-channel full-duplex status |
| led_drive_o | output | NUM_CH | Pull-low enable per pad, 1 = lamp lit |

## Verification
A vector table runs the static modes against link and duplex status patterns that differ between channels, such as 1010 against 0101. This separates link-following from duplex-following and catches a channel that reads its neighbour's bit. Other vectors mix channels with different codes, including the reserved codes, and show that one channel's field cannot leak into another. Global-override vectors set per-channel fields that disagree with the global code, so ignoring the override shows up at once. Directed runs then measure the flash half-period lengths, the lockstep between channels, the lit start after the strap window, the strap window length and power-down release.

// File: rtl/led_ind_pkg.sv
package led_ind_pkg;

    typedef enum logic [2:0] {
        LM_LINK  = 3'd0,
        LM_DUPLX = 3'd1,
        LM_ON    = 3'd2,
        LM_OFF   = 3'd3,
        LM_FLASH = 3'd4
    } led_mode_e;

    localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/led_flash_timer.sv
module led_flash_timer #(
    parameter int unsigned HALF_CYCLES = 1_000_000
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic lit_o
);
    localparam int unsigned CW = $clog2(HALF_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lit;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.lit = ~st_q.lit;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.cnt <= '0;
            st_q.lit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lit_o = st_q.lit;

    // R7
    flash_toggle_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(st_q.lit) |-> ($past(st_q.cnt) == LAST));

    // R7
    flash_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        st_q.cnt <= LAST);

endmodule

// File: rtl/led_strap_window.sv
module led_strap_window #(
    parameter int unsigned HOLD_CYCLES = 1024
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] DONE = CW'(HOLD_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != DONE) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.cnt != DONE);

    // R2
    strap_once_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !busy_o |=> !busy_o);

endmodule

// File: rtl/led_mode_sel.sv
module led_mode_sel
    import led_ind_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              link_i,
    input  logic              dup_i,
    input  logic              flash_lit_i,
    output logic              want_on_o
);
    always_comb begin
        case (mode_i)
            LM_LINK:  want_on_o = link_i;
            LM_DUPLX: want_on_o = dup_i;
            LM_ON:    want_on_o = 1'b1;
            LM_FLASH: want_on_o = flash_lit_i;
            default:  want_on_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/led_ind_top.sv
module led_ind_top
    import led_ind_pkg::*;
#(
    parameter int unsigned NUM_CH            = 4,
    parameter int unsigned BLINK_HALF_CYCLES = 1_000_000,
    parameter int unsigned STRAP_CYCLES      = 1024
) (
    input  logic                       clk_i,
    input  logic                       rst_n_i,
    input  logic                       pwrdn_i,
    input  logic                       glb_sel_en_i,
    input  logic [MODE_W-1:0]          glb_sel_i,
    input  logic [NUM_CH*MODE_W-1:0]   ch_sel_i,
    input  logic [NUM_CH-1:0]          link_up_i,
    input  logic [NUM_CH-1:0]          full_dup_i,
    output logic [NUM_CH-1:0]          led_drive_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] drive;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                    flash_lit;
    logic                    strap_busy;
    logic [NUM_CH-1:0]       want_on;
    logic [MODE_W-1:0]       eff_mode [NUM_CH];

    led_flash_timer #(
        .HALF_CYCLES (BLINK_HALF_CYCLES)
    ) u_flash (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .lit_o   (flash_lit)
    );

    led_strap_window #(
        .HOLD_CYCLES (STRAP_CYCLES)
    ) u_strap (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .busy_o  (strap_busy)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign eff_mode[n] = glb_sel_en_i ? glb_sel_i : ch_sel_i[n*MODE_W +: MODE_W];

        led_mode_sel u_sel (
            .mode_i      (eff_mode[n]),
            .link_i      (link_up_i[n]),
            .dup_i       (full_dup_i[n]),
            .flash_lit_i (flash_lit),
            .want_on_o   (want_on[n])
        );

        // R5
        forced_on_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (!strap_busy && !pwrdn_i && eff_mode[n] == LM_ON) |=> led_drive_o[n]);

        // R6
        reserved_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (eff_mode[n] > LM_FLASH || eff_mode[n] == LM_OFF) |=> !led_drive_o[n]);

        // R3
        link_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (!strap_busy && !pwrdn_i && eff_mode[n] == LM_LINK)
                |=> (led_drive_o[n] == $past(link_up_i[n])));

        // R8
        flash_lockstep_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (!strap_busy && !pwrdn_i && eff_mode[n] == LM_FLASH)
                |=> (led_drive_o[n] == $past(flash_lit)));
    end

    always_comb begin
        st_d = st_q;
        if (strap_busy || pwrdn_i) begin
            st_d.drive = '0;
        end else begin
            st_d.drive = want_on;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.drive <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign led_drive_o = st_q.drive;

    // R11
    pwrdn_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        pwrdn_i |=> (led_drive_o == '0));

    // R2
    strap_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        strap_busy |=> (led_drive_o == '0));

endmodule

// File: tb/led_ind_top_tb.sv
module led_ind_top_tb;
    localparam int unsigned NCH   = 4;
    localparam int unsigned HALF  = 16;
    localparam int unsigned STRAP = 4;
    localparam int unsigned VW    = 1 + 3 + 12 + 4 + 4 + 1 + 4;
    localparam int unsigned NVEC  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn = 1'b0;
    logic        gen = 1'b0;
    logic [2:0]  gsel = 3'd0;
    logic [11:0] csel = '0;
    logic [3:0]  link = '0;
    logic [3:0]  dup = '0;
    logic [3:0]  led;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    led_ind_top #(
        .NUM_CH(NCH), .BLINK_HALF_CYCLES(HALF), .STRAP_CYCLES(STRAP)
    ) u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .pwrdn_i(pwrdn),
        .glb_sel_en_i(gen), .glb_sel_i(gsel), .ch_sel_i(csel),
        .link_up_i(link), .full_dup_i(dup), .led_drive_o(led)
    );

    // fields: gen, gsel, csel {ch3,ch2,ch1,ch0}, link, dup, pwrdn, expected
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {1'b0, 3'd0, {3'd3,3'd2,3'd1,3'd0}, 4'b0001, 4'b0010, 1'b0, 4'b0111}, // R12
        {1'b0, 3'd0, {3'd3,3'd2,3'd1,3'd0}, 4'b0000, 4'b0000, 1'b0, 4'b0100}, // R5
        {1'b0, 3'd0, {3'd0,3'd0,3'd0,3'd0}, 4'b1010, 4'b0101, 1'b0, 4'b1010}, // R3
        {1'b0, 3'd0, {3'd1,3'd1,3'd1,3'd1}, 4'b1010, 4'b0101, 1'b0, 4'b0101}, // R4
        {1'b0, 3'd0, {3'd5,3'd6,3'd7,3'd3}, 4'b1111, 4'b1111, 1'b0, 4'b0000}, // R6
        {1'b0, 3'd0, {3'd2,3'd5,3'd2,3'd7}, 4'b1111, 4'b1111, 1'b0, 4'b1010}, // R6
        {1'b1, 3'd2, {3'd3,3'd3,3'd3,3'd3}, 4'b0000, 4'b0000, 1'b0, 4'b1111}, // R10
        {1'b1, 3'd3, {3'd2,3'd2,3'd2,3'd2}, 4'b1111, 4'b1111, 1'b0, 4'b0000}, // R10
        {1'b1, 3'd0, {3'd2,3'd2,3'd2,3'd2}, 4'b0110, 4'b1001, 1'b0, 4'b0110}, // R10
        {1'b1, 3'd6, {3'd2,3'd2,3'd2,3'd2}, 4'b1111, 4'b1111, 1'b0, 4'b0000}, // R10
        {1'b0, 3'd0, {3'd2,3'd2,3'd2,3'd2}, 4'b1111, 4'b1111, 1'b1, 4'b0000}, // R11
        {1'b1, 3'd1, {3'd0,3'd0,3'd0,3'd0}, 4'b0110, 4'b1001, 1'b0, 4'b1001}  // R4
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R12";  1: return "R5";   2: return "R3";   3: return "R4";
            4: return "R6";   5: return "R6";   6: return "R10";  7: return "R10";
            8: return "R10";  9: return "R10";  10: return "R11"; default: return "R4";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int run;
        int run2;
        logic [3:0] cur;
        logic [3:0] cur2;
        bit split;

        // R1: outputs released during reset with modes requesting light
        csel = {3'd3, 3'd0, 3'd4, 3'd2};
        link = 4'b0100;
        repeat (3) step();
        check("R1", 32'(led), 32'h0);

        // R2: strap window after reset release
        rst_n = 1'b1;
        for (int k = 1; k <= STRAP; k++) begin
            step();
            check("R2", 32'(led), 32'h0);
        end
        step();
        // ch0 on, ch1 flash lit (R9), ch2 link=1, ch3 off
        check("R2", 32'(led[0]), 32'h1);
        check("R9", 32'(led[1]), 32'h1);
        check("R3", 32'(led[2]), 32'h1);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            {gen, gsel, csel, link, dup, pwrdn} = VEC[i][VW-1:4];
            step();
            check(vec_tag(i), 32'(led), 32'(VEC[i][3:0]));
        end

        // R11: resume after power-down release
        pwrdn = 1'b0;
        gen = 1'b0;
        csel = {3'd2, 3'd2, 3'd2, 3'd2};
        step();
        check("R11", 32'(led), 32'hF);
        pwrdn = 1'b1;
        step();
        check("R11", 32'(led), 32'h0);
        pwrdn = 1'b0;

        // R7 / R8: flash period and lockstep
        csel = {3'd4, 3'd4, 3'd4, 3'd4};
        step();
        split = 1'b0;
        cur = led;
        for (int k = 0; k < 4 * HALF; k++) begin
            step();
            if (led != 4'h0 && led != 4'hF) split = 1'b1;
            if (led != cur) break;
        end
        cur = led;
        run = 1;
        for (int k = 0; k < 4 * HALF; k++) begin
            step();
            if (led != 4'h0 && led != 4'hF) split = 1'b1;
            if (led != cur) break;
            run++;
        end
        cur2 = led;
        run2 = 1;
        for (int k = 0; k < 4 * HALF; k++) begin
            step();
            if (led != 4'h0 && led != 4'hF) split = 1'b1;
            if (led != cur2) break;
            run2++;
        end
        check("R7", 32'(run), 32'(HALF));
        check("R7", 32'(run2), 32'(HALF));
        check("R7", 32'(cur2 == ~cur), 32'h1);
        check("R8", 32'(split), 32'h0);

        // R12: flash on one channel does not disturb static neighbours
        csel = {3'd3, 3'd2, 3'd4, 3'd2};
        step();
        check("R12", 32'({led[3], led[2], led[0]}), 32'b011);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule